// File: doc/BRIEF.md
# Converter Serial Result Port

This block moves the 18-bit result of a sampling converter out over a one-wire serial data line, most significant bit first. A modelled converter core presents a result word with a one-cycle completion strobe and a busy level that is high while a conversion runs. The port keeps the latest result and shifts it out of its own shift register.

In master mode the port makes its own serial clock from the system clock and frames each word with a frame-sync output. The host can shift either after the conversion completes, with a selectable clock divider, or during the next conversion, which sends the previous result at the fastest rate. In slave mode the host supplies the serial clock. The port brings that clock into the system clock domain and acts on its active edges. Bits from a downstream device on the serial input follow the local word onto the output, so several converters can share one line. If the host is too slow, a new result arrives while a slave read is still running. The port then drops the partial read and pulses an error output.

Top module: `ser_result_port`

## Requirements
- R1: A high `done_i` at a clock edge stores `result_i`. In master read-after-convert mode (`slave_sel_i`=0, `rd_during_i`=0), that same edge starts a read of the new word unless a read is already running. From the next cycle, `fsync_o` is active and `sdout_o` carries bit 17.
- R2: A master read sends all 18 bits MSB first. Each bit lasts one internal clock period of 2·H system cycles, where H = 2^`div_i` (0 gives divide by 2, 3 gives divide by 16). The internal clock is low for the first H cycles of each bit and high for the last H cycles. After 36·H cycles the read is over.
- R3: `fsync_o` is active high when `sync_pol_i`=0 and active low when `sync_pol_i`=1. It stays active for exactly the 36·H cycles of a master read.
- R4: `clk_inv_i`=1 inverts `sclk_o` in master mode. In slave mode it makes the falling edge of `sclk_i` the active edge instead of the rising edge.
- R5: In master read-during-convert mode (`rd_during_i`=1), `done_i` starts no read. A rising edge of `busy_i` starts a read of the stored result with H=1, whatever the value of `div_i`.
- R6: In master mode with no read running, `sdout_o` is 0, `fsync_o` is at its inactive level and `sclk_o` equals `clk_inv_i`.
- R7: In slave mode, a result stored by `done_i` is loaded on the next active `sclk_i` edge. After the k-th active edge of the read (k = 1..18), `sdout_o` shows result bit 18−k. `sdout_o` becomes valid once two synchroniser stages and one edge-detect stage have passed, three system cycles after the pin changes.
- R8: In slave mode, the level on `sdin_i` at an active edge appears on `sdout_o` 18 active edges later. A bit sampled at the first edge of a read is therefore output at edge 19.
- R9: If `done_i` arrives in slave mode while fewer than 18 edges of a read have passed, `rd_err_o` is high for exactly one cycle, starting the cycle after that `done_i`. The partial read is dropped, and the next active edge loads the new result.
- R10: `rd_err_o` never rises in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| result_i | input | 18 | Conversion result from the core |
| done_i | input | 1 | One-cycle conversion-complete strobe |
| busy_i | input | 1 | High while a conversion runs |
| slave_sel_i | input | 1 | 0 internal serial clock (master), 1 external (slave) |
| rd_during_i | input | 1 | Master read timing: 1 during conversion, 0 after |
| div_i | input | 2 | Master read-after-convert clock divider |
| sync_pol_i | input | 1 | Frame-sync polarity: 0 active high |
| clk_inv_i | input | 1 | Serial clock inversion / active edge select |
| sclk_i | input | 1 | External serial clock (slave) |
| sdin_i | input | 1 | Daisy-chain serial input (slave) |
| sclk_o | output | 1 | Internal serial clock (master) |
| sdout_o | output | 1 | Serial data output |
| fsync_o | output | 1 | Frame sync (master) |
| rd_err_o | output | 1 | Incomplete-read error pulse |

## Verification
In master mode, the first bit and an active frame sync show up one cycle after the edge that samples `done_i` or the rise of `busy_i`. Bit b then holds from cycle 2·H·b to cycle 2·H·(b+1)−1 after that edge, and the line goes idle at cycle 36·H. The bench samples every cycle of the read on the falling clock edge and compares each sample against that schedule. In slave mode, an edge on `sclk_i` takes effect on the third rising system edge. The bench therefore holds each level for four cycles and checks the data only after that. The error pulse is checked in the first cycle after `done_i` and found gone in the cycle after that.

// File: rtl/ser_pkg.sv
// Shared types for the serial result port.
// Assumes: nothing beyond the package itself.
package ser_pkg;

    // Static configuration pins, gathered in one place for the top level.
    typedef struct packed {
        logic slave;
        logic rd_during;
        logic pol;
        logic inv;
    } port_cfg_t;

endpackage

// File: rtl/ser_sync.sv
// Level synchroniser: a chain of STAGES flops that brings an asynchronous pin
// into the clk domain.
// Assumes: the pin is slow relative to clk (held for at least two cycles).
module ser_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] ff;

    generate
        if (STAGES == 1) begin : g_one
            // Single-flop variant.
            always_ff @(posedge clk) begin
                if (!rst_n) ff <= '0;
                else        ff <= d_i;
            end
        end else begin : g_chain
            // Shift the pin through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) ff <= '0;
                else        ff <= {ff[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = ff[STAGES-1];
endmodule

// File: rtl/ser_master_seq.sv
// Master sequencer: makes the internal serial clock (half period 2^div cycles)
// and shifts a word out MSB first, one bit per internal clock period.
// Assumes: start_i is raised only while active_o is low.
module ser_master_seq #(
    parameter int WORD_W = 18,
    parameter int DIV_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [DIV_W-1:0]  div_i,
    output logic              active_o,
    output logic              sclk_raw_o,
    output logic              bit_o
);
    localparam int HALF_MAX = 1 << ((1 << DIV_W) - 1);
    localparam int CNT_W    = (HALF_MAX > 1) ? $clog2(HALF_MAX) : 1;
    localparam int BIT_W    = $clog2(WORD_W);

    logic              active, half;
    logic [CNT_W-1:0]  ph_cnt;
    logic [BIT_W-1:0]  bit_cnt;
    logic [WORD_W-1:0] sr;
    logic [DIV_W-1:0]  div_q;
    logic [CNT_W:0]    h_len, h_last;
    logic              ph_end, last_bit;

    // Decode the end of a half period and the last bit.
    always_comb begin
        h_len    = (CNT_W+1)'(1) << div_q;
        h_last   = h_len - (CNT_W+1)'(1);
        ph_end   = ({1'b0, ph_cnt} == h_last);
        last_bit = (bit_cnt == BIT_W'(WORD_W-1));
    end

    // Phase counter, clock level, bit counter and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            half    <= 1'b0;
            ph_cnt  <= '0;
            bit_cnt <= '0;
            sr      <= '0;
            div_q   <= '0;
        end else if (start_i) begin
            active  <= 1'b1;
            half    <= 1'b0;
            ph_cnt  <= '0;
            bit_cnt <= '0;
            sr      <= word_i;
            div_q   <= div_i;
        end else if (active) begin
            if (ph_end) begin
                ph_cnt <= '0;
                half   <= ~half;
                if (half) begin
                    sr      <= {sr[WORD_W-2:0], 1'b0};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (last_bit) active <= 1'b0;
                end
            end else begin
                ph_cnt <= ph_cnt + 1'b1;
            end
        end
    end

    assign active_o   = active;
    assign sclk_raw_o = active & half;
    assign bit_o      = sr[WORD_W-1];
endmodule

// File: rtl/ser_slave_seq.sv
// Slave sequencer: synchronises the external clock and serial input, finds
// active edges, loads a pending result, shifts it out with daisy-chain data
// behind it and flags reads that a new result cuts short.
// Assumes: sclk_i and sdin_i hold each level for at least two clk cycles.
module ser_slave_seq #(
    parameter int WORD_W      = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              inv_i,
    input  logic              sclk_i,
    input  logic              sdin_i,
    input  logic              done_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              sdout_o,
    output logic              err_o
);
    localparam int CNT_W = $clog2(WORD_W + 1);

    logic             sclk_s, sclk_d, sdin_s, act_edge;
    logic             pending, active, err;
    logic [CNT_W-1:0] cnt;
    logic [WORD_W:0]  sr;

    ser_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .d_i(sclk_i), .q_o(sclk_s));
    ser_sync #(.STAGES(SYNC_STAGES)) u_sdin_sync (
        .clk(clk), .rst_n(rst_n), .d_i(sdin_i), .q_o(sdin_s));

    // Previous synchronised clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    // Active edge: the rising edge of the clock after optional inversion.
    assign act_edge = enable_i & (sclk_s ^ inv_i) & ~(sclk_d ^ inv_i);

    // Read control, daisy shift register and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            active  <= 1'b0;
            cnt     <= '0;
            sr      <= '0;
            err     <= 1'b0;
        end else begin
            err <= 1'b0;
            if (!enable_i) begin
                pending <= 1'b0;
                active  <= 1'b0;
            end else if (done_i) begin
                pending <= 1'b1;
                if (active) begin
                    err    <= 1'b1;
                    active <= 1'b0;
                end
            end else if (act_edge) begin
                if (pending) begin
                    sr      <= {word_i, sdin_s};
                    pending <= 1'b0;
                    active  <= 1'b1;
                    cnt     <= CNT_W'(1);
                end else begin
                    sr <= {sr[WORD_W-1:0], sdin_s};
                    if (active) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(WORD_W-1)) active <= 1'b0;
                    end
                end
            end
        end
    end

    assign sdout_o = sr[WORD_W];
    assign err_o   = err;
endmodule

// File: rtl/ser_result_port.sv
// Serial result port top: stores conversion results, picks master or slave
// clocking, starts master reads and drives the serial pins.
// Assumes: mode and polarity pins change only while no read is running.
module ser_result_port #(
    parameter int WORD_W      = 18,
    parameter int DIV_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] result_i,
    input  logic              done_i,
    input  logic              busy_i,
    input  logic              slave_sel_i,
    input  logic              rd_during_i,
    input  logic [DIV_W-1:0]  div_i,
    input  logic              sync_pol_i,
    input  logic              clk_inv_i,
    input  logic              sclk_i,
    input  logic              sdin_i,
    output logic              sclk_o,
    output logic              sdout_o,
    output logic              fsync_o,
    output logic              rd_err_o
);
    import ser_pkg::*;

    port_cfg_t         cfg;
    logic [WORD_W-1:0] result_q;
    logic              busy_q, m_start, m_active, m_sclk, m_bit;
    logic [WORD_W-1:0] m_word;
    logic [DIV_W-1:0]  m_div;
    logic              s_sdout, s_err;

    assign cfg = '{slave: slave_sel_i, rd_during: rd_during_i,
                   pol: sync_pol_i, inv: clk_inv_i};

    // Result store and busy history for the read-during start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            busy_q   <= 1'b0;
        end else begin
            if (done_i) result_q <= result_i;
            busy_q <= busy_i;
        end
    end

    // Master start condition, word source and effective divider.
    always_comb begin
        m_start = !cfg.slave && !m_active &&
                  (cfg.rd_during ? (busy_i && !busy_q) : done_i);
        m_word  = cfg.rd_during ? result_q : result_i;
        m_div   = cfg.rd_during ? '0 : div_i;
    end

    ser_master_seq #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_master (
        .clk(clk), .rst_n(rst_n), .start_i(m_start), .word_i(m_word),
        .div_i(m_div), .active_o(m_active), .sclk_raw_o(m_sclk), .bit_o(m_bit));

    ser_slave_seq #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_slave (
        .clk(clk), .rst_n(rst_n), .enable_i(cfg.slave), .inv_i(cfg.inv),
        .sclk_i(sclk_i), .sdin_i(sdin_i), .done_i(done_i), .word_i(result_q),
        .sdout_o(s_sdout), .err_o(s_err));

    // Pin multiplexing between master and slave paths.
    always_comb begin
        sdout_o  = cfg.slave ? s_sdout : (m_active & m_bit);
        fsync_o  = cfg.slave ? cfg.pol : (m_active ^ cfg.pol);
        sclk_o   = cfg.slave ? 1'b0 : (m_sclk ^ cfg.inv);
        rd_err_o = s_err;
    end
endmodule

// File: rtl/ser_result_port_chk.sv
// Assertion checker for the serial result port, bound to every instance.
module ser_result_port_chk (
    input logic clk,
    input logic rst_n,
    input logic slave_sel_i,
    input logic sync_pol_i,
    input logic clk_inv_i,
    input logic sclk_o,
    input logic sdout_o,
    input logic fsync_o,
    input logic rd_err_o
);
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err_o |=> !rd_err_o); // R9

    AST_ERR_SLAVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err_o |-> $past(slave_sel_i)); // R10

    AST_IDLE_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_sel_i && fsync_o == sync_pol_i) |-> !sdout_o); // R6

    AST_IDLE_CLK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_sel_i && fsync_o == sync_pol_i) |-> (sclk_o == clk_inv_i)); // R6

    AST_DATA_ON_CLK_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!slave_sel_i && $stable(slave_sel_i) && $stable(sync_pol_i) &&
         $stable(clk_inv_i) && fsync_o != sync_pol_i && $stable(fsync_o) &&
         $stable(sclk_o)) |-> $stable(sdout_o)); // R2
endmodule

bind ser_result_port ser_result_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .slave_sel_i(slave_sel_i),
    .sync_pol_i(sync_pol_i), .clk_inv_i(clk_inv_i), .sclk_o(sclk_o),
    .sdout_o(sdout_o), .fsync_o(fsync_o), .rd_err_o(rd_err_o));

// File: tb/ser_result_port_test.sv
`timescale 1ns/1ps
module ser_result_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] result_i = '0;
    logic        done_i = 1'b0, busy_i = 1'b0;
    logic        slave_sel_i = 1'b0, rd_during_i = 1'b0;
    logic [1:0]  div_i = 2'd0;
    logic        sync_pol_i = 1'b0, clk_inv_i = 1'b0;
    logic        sclk_i = 1'b0, sdin_i = 1'b0;
    logic        sclk_o, sdout_o, fsync_o, rd_err_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ser_result_port uut (
        .clk(clk), .rst_n(rst_n), .result_i(result_i), .done_i(done_i),
        .busy_i(busy_i), .slave_sel_i(slave_sel_i), .rd_during_i(rd_during_i),
        .div_i(div_i), .sync_pol_i(sync_pol_i), .clk_inv_i(clk_inv_i),
        .sclk_i(sclk_i), .sdin_i(sdin_i), .sclk_o(sclk_o), .sdout_o(sdout_o),
        .fsync_o(fsync_o), .rd_err_o(rd_err_o));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reset state, sampled after release.
    task automatic t_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sdout_o == 1'b0, "R6 reset sdout", sdout_o, 0);
        chk(fsync_o == 1'b0, "R6 reset fsync", fsync_o, 0);
        chk(sclk_o == 1'b0, "R6 reset sclk", sclk_o, 0);
        chk(rd_err_o == 1'b0, "R10 reset err", rd_err_o, 0);
    endtask

    // Called at the negedge right after the starting edge; follows the whole read.
    task automatic follow_master(input logic [17:0] w, input int h, input bit pol, input bit inv);
        for (int n = 0; n <= 36*h; n++) begin
            bit esd, efs, esc;
            if (n < 36*h) begin
                esd = w[17 - n/(2*h)];
                efs = ~pol;
                esc = ((n % (2*h)) >= h) ^ inv;
            end else begin
                esd = 1'b0;
                efs = pol;
                esc = inv;
            end
            chk(sdout_o == esd, "R2 master data bit", sdout_o, esd);
            chk(fsync_o == efs, "R3 frame sync level", fsync_o, efs);
            chk(sclk_o == esc, "R4 internal clock level", sclk_o, esc);
            chk(rd_err_o == 1'b0, "R10 no error in master", rd_err_o, 0);
            @(negedge clk);
        end
    endtask

    // Read-after-convert with a given divider, polarity and inversion.
    task automatic t_master_after(input logic [17:0] w, input logic [1:0] d, input bit pol, input bit inv);
        slave_sel_i = 1'b0; rd_during_i = 1'b0;
        div_i = d; sync_pol_i = pol; clk_inv_i = inv;
        repeat (2) @(negedge clk);
        chk(fsync_o == pol, "R6 idle fsync", fsync_o, pol);
        chk(sclk_o == inv, "R6 idle sclk", sclk_o, inv);
        result_i = w; done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
        // R1: read begins one cycle after done
        follow_master(w, 1 << d, pol, inv);
    endtask

    // Read-during-convert: done does not start, busy rise does, divider ignored.
    task automatic t_master_during(input logic [17:0] w);
        slave_sel_i = 1'b0; rd_during_i = 1'b1; div_i = 2'd3;
        sync_pol_i = 1'b0; clk_inv_i = 1'b0;
        @(negedge clk);
        result_i = w; done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
        chk(fsync_o == 1'b0, "R5 done starts nothing", fsync_o, 0);
        @(negedge clk);
        chk(fsync_o == 1'b0, "R5 still idle", fsync_o, 0);
        busy_i = 1'b1;
        @(negedge clk);
        follow_master(w, 1, 1'b0, 1'b0);
        busy_i = 1'b0;
        rd_during_i = 1'b0;
        @(negedge clk);
    endtask

    // One active edge of the external clock, then its return to idle.
    task automatic s_edge(input bit sd, input bit inv);
        sclk_i = ~inv; sdin_i = sd;
        repeat (4) @(negedge clk);
        sclk_i = inv;
        repeat (4) @(negedge clk);
    endtask

    task automatic enter_slave(input bit inv);
        slave_sel_i = 1'b1; clk_inv_i = inv; sclk_i = inv; sdin_i = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // Slave read of one word plus two daisy-chain bits.
    task automatic t_slave_daisy(input logic [17:0] w);
        enter_slave(1'b0);
        result_i = w; done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
        chk(fsync_o == 1'b0, "R6 slave frame sync inactive", fsync_o, 0);
        for (int k = 1; k <= 20; k++) begin
            bit v, e;
            v = (k == 1) ? 1'b1 : (k == 2) ? 1'b0 : k[0];
            s_edge(v, 1'b0);
            if (k <= 18) begin
                e = w[18-k];
                chk(sdout_o == e, "R7 slave data bit", sdout_o, e);
            end else begin
                e = (k == 19) ? 1'b1 : 1'b0;
                chk(sdout_o == e, "R8 daisy bit after 18 edges", sdout_o, e);
            end
        end
        slave_sel_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Inverted-edge slave read cut short by a new result.
    task automatic t_slave_abort(input logic [17:0] a, input logic [17:0] b);
        enter_slave(1'b1);
        result_i = a; done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
        for (int k = 1; k <= 5; k++) begin
            s_edge(1'b0, 1'b1);
            chk(sdout_o == a[18-k], "R4 falling active edge data", sdout_o, a[18-k]);
        end
        chk(rd_err_o == 1'b0, "R9 no error yet", rd_err_o, 0);
        result_i = b; done_i = 1'b1;
        @(negedge clk);
        done_i = 1'b0;
        chk(rd_err_o == 1'b1, "R9 error pulse", rd_err_o, 1);
        @(negedge clk);
        chk(rd_err_o == 1'b0, "R9 pulse one cycle", rd_err_o, 0);
        for (int k = 1; k <= 3; k++) begin
            s_edge(1'b0, 1'b1);
            chk(sdout_o == b[18-k], "R9 new word after abort", sdout_o, b[18-k]);
        end
        slave_sel_i = 1'b0; clk_inv_i = 1'b0; sclk_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_master_after(18'h2D5A7, 2'd0, 1'b0, 1'b0);
        t_master_after(18'h1C3E9, 2'd3, 1'b1, 1'b1);
        t_master_after(18'h3F00F, 2'd1, 1'b0, 1'b1);
        t_master_during(18'h25A5A);
        t_slave_daisy(18'h3A5C3);
        t_slave_abort(18'h2AAAA, 18'h15555);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule